// File: doc/BRIEF.md
# Randomized Liveness Ping Scheduler

This block checks that the alert receivers and escalation senders of a chip are still alive. It sends them pings one at a time and watches for the replies. The targets are picked by a 32-bit LFSR whose seed and output bit scramble are fixed at elaboration. After a random pause of 1 to 16 cycles, a round starts. Each round pings one alert receiver, chosen among those that are both enabled and locked, and then one escalation sender. Each ping is held until the pinged target acknowledges it or a programmable number of cycles runs out. If the ping runs out, a one-cycle failure pulse goes out on the failure output for that kind of target.

The scheduler starts once its enable is set, and the enable can never be cleared again. It has a sparsely encoded state register and two copies of its cycle counter. A local escalation input, a mismatch between the counter copies, or an unknown state code drops it into a terminal fault state. From that state no ping or failure pulse is produced until reset.

Top module: `ping_sched`

## Requirements
- R1: After reset, all ping and failure outputs are low, and the response limit is 256 cycles: an unanswered ping issued without any limit write stays high for exactly 256 cycles.
- R2: No ping is issued until a 1 has been written to the enable (`en_wr_i` high with `en_i` = 1). A later write with `en_i` = 0 does not stop the pinging.
- R3: An alert ping only goes to alert `i` when `alert_en_i[i]` = 1 and `alert_open_i[i]` = 0 (enabled and locked).
- R4: At most one ping output bit (across `alert_ping_o` and `esc_ping_o` together) is high in any cycle.
- R5: Each round starts after a wait of at least one cycle with no ping. If any alert is eligible, the round issues one alert ping, and the escalation ping starts in the very cycle the alert ping drops.
- R6: When no alert is eligible, the alert slot is skipped: no alert ping and no alert failure occur, and escalation pings continue.
- R7: If the pinged target's acknowledge is high in the k-th cycle of the ping (k no larger than the limit), the ping lasts exactly k cycles and no failure pulse is raised.
- R8: An unanswered ping stays high for max(T,1) cycles, where T is the limit. In the first cycle after it drops, `alert_fail_o` (for an alert ping) or `esc_fail_o` (for an escalation ping) is high for exactly one cycle. Failure outputs are never high at any other time.
- R9: Acknowledges from targets that are not being pinged, including late ones after a ping ended, are ignored: they neither shorten a ping nor suppress its failure.
- R10: A high `local_esc_i` sends the scheduler to a terminal fault state. From the next cycle on, all ping and failure outputs stay low until reset. An unknown state code or a mismatch between the two counter copies leads to the same state.
- R11: A write with `tmo_wr_i` high loads `tmo_i` as the limit T for later pings. T = 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr_i | input | 1 | Enable write strobe |
| en_i | input | 1 | Enable write value; only a 1 has any effect |
| tmo_wr_i | input | 1 | Response limit write strobe |
| tmo_i | input | CNT_W | Response limit in cycles |
| alert_en_i | input | N_ALERT | Per-alert enable |
| alert_open_i | input | N_ALERT | Per-alert configuration still writable (0 = locked) |
| alert_ack_i | input | N_ALERT | Per-alert ping acknowledge |
| esc_ack_i | input | N_ESC | Per-escalation-sender ping acknowledge |
| local_esc_i | input | 1 | Local escalation, forces the fault state |
| alert_ping_o | output | N_ALERT | One-hot alert ping request |
| esc_ping_o | output | N_ESC | One-hot escalation ping request |
| alert_fail_o | output | 1 | Alert ping failure pulse |
| esc_fail_o | output | 1 | Escalation ping failure pulse |

## Verification
The hardest case to reach from the ports is an acknowledge that lands on the last allowed cycle of a ping, or one that comes from the wrong or an expired target. Both must be told apart from a genuine timeout even though the target sequence is pseudo-random. The bench does not predict the LFSR. Its responder reacts to each ping as it appears: it picks a random reply cycle between 1 and the limit, or no reply at all, and in a noise mode it holds every non-pinged acknowledge high. The expected length of each ping and its failure pulse then follow from that choice alone. Phases with no eligible alert, a zero limit and a local escalation issued in the middle of a ping cover the remaining edges.

// File: rtl/ping_pkg.sv
`timescale 1ns/1ps
package ping_pkg;
  // Sparse state codes, pairwise at least two bits apart.
  typedef enum logic [5:0] {
    PS_IDLE  = 6'b001011,
    PS_WAIT  = 6'b010101,
    PS_APING = 6'b100110,
    PS_EPING = 6'b111000,
    PS_FAULT = 6'b011110
  } ping_st_e;
endpackage

// File: rtl/ping_lfsr.sv
`timescale 1ns/1ps
module ping_lfsr #(
  parameter int unsigned     W        = 32,
  parameter logic [W-1:0]    SEED     = 32'h5A3C_96E1,
  parameter logic [W-1:0]    TAPS     = 32'h8020_0003,
  parameter int unsigned     PERM_MUL = 13,
  parameter int unsigned     PERM_ADD = 7,
  parameter int unsigned     OUT_W    = 9
) (
  input  logic             clk,
  input  logic             rst,
  output logic [OUT_W-1:0] rnd_o
);
  logic [W-1:0] st;

  // Galois form, advances every cycle
  always_ff @(posedge clk) begin
    if (rst) st <= SEED;
    else     st <= {1'b0, st[W-1:1]} ^ (st[0] ? TAPS : '0);
  end

  // Fixed scramble of output bits: odd multiplier gives a bijection mod W
  for (genvar i = 0; i < OUT_W; i++) begin : g_perm
    assign rnd_o[i] = st[(i * PERM_MUL + PERM_ADD) % W];
  end

  p_lfsr_live_r5: assert property (@(posedge clk) disable iff (rst) st != '0);
endmodule

// File: rtl/ping_dual_cnt.sv
`timescale 1ns/1ps
module ping_dual_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         mismatch_o
);
  logic [W-1:0] cnt_a, cnt_b;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_a <= '0;
    else if (inc_i)   cnt_a <= cnt_a + W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_b <= '0;
    else if (inc_i)   cnt_b <= cnt_b + W'(1);
  end

  assign cnt_o      = cnt_a;
  assign mismatch_o = (cnt_a != cnt_b);

  p_cnt_clear_r8: assert property (@(posedge clk) disable iff (rst) clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/ping_pick.sv
`timescale 1ns/1ps
module ping_pick #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [IDX_W-1:0] start_i,
  input  logic [N-1:0]     elig_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  int c;

  // First eligible index at or after the random start, wrapping around
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    c       = 0;
    for (int k = 0; k < N; k++) begin
      c = (int'(start_i) + k) % N;
      if (!found_o && elig_i[c]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(c);
      end
    end
  end

  always_comb begin
    a_pick_elig_r3: assert (!found_o || elig_i[idx_o]);
  end
endmodule

// File: rtl/ping_sched.sv
`timescale 1ns/1ps
module ping_sched
  import ping_pkg::*;
#(
  parameter int unsigned N_ALERT   = 8,
  parameter int unsigned N_ESC     = 4,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned TMO_RST   = 256,
  parameter int unsigned WAIT_W    = 4,
  parameter int unsigned LFSR_W    = 32,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 32'h5A3C_96E1,
  parameter int unsigned PERM_MUL  = 13,
  parameter int unsigned PERM_ADD  = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_wr_i,
  input  logic               en_i,
  input  logic               tmo_wr_i,
  input  logic [CNT_W-1:0]   tmo_i,
  input  logic [N_ALERT-1:0] alert_en_i,
  input  logic [N_ALERT-1:0] alert_open_i,
  input  logic [N_ALERT-1:0] alert_ack_i,
  input  logic [N_ESC-1:0]   esc_ack_i,
  input  logic               local_esc_i,
  output logic [N_ALERT-1:0] alert_ping_o,
  output logic [N_ESC-1:0]   esc_ping_o,
  output logic               alert_fail_o,
  output logic               esc_fail_o
);
  localparam int unsigned A_IDX_W = (N_ALERT > 1) ? $clog2(N_ALERT) : 1;
  localparam int unsigned E_IDX_W = (N_ESC > 1) ? $clog2(N_ESC) : 1;
  localparam int unsigned RND_W   = WAIT_W + A_IDX_W + E_IDX_W;

  ping_st_e           st, st_n;
  logic               en_q;
  logic [CNT_W-1:0]   tmo_q, cnt;
  logic [CNT_W:0]     cnt_nx;
  logic [WAIT_W-1:0]  wait_len;
  logic [A_IDX_W-1:0] a_tgt, a_start, a_pick;
  logic [E_IDX_W-1:0] e_tgt, e_pick;
  logic [RND_W-1:0]   rnd;
  logic [N_ALERT-1:0] elig;
  logic               a_found, cnt_bad, tmo_hit;
  logic               cnt_clr, cnt_inc, go_w, go_a, go_e, afail_n, efail_n;

  ping_lfsr #(
    .W(LFSR_W), .SEED(LFSR_SEED), .TAPS(LFSR_W'(32'h8020_0003)),
    .PERM_MUL(PERM_MUL), .PERM_ADD(PERM_ADD), .OUT_W(RND_W)
  ) u_lfsr (.clk(clk), .rst(rst), .rnd_o(rnd));

  assign elig    = alert_en_i & ~alert_open_i;
  assign a_start = A_IDX_W'(int'(rnd[WAIT_W +: A_IDX_W]) % N_ALERT);
  assign e_pick  = E_IDX_W'(int'(rnd[WAIT_W + A_IDX_W +: E_IDX_W]) % N_ESC);

  ping_pick #(.N(N_ALERT), .IDX_W(A_IDX_W)) u_pick (
    .start_i(a_start), .elig_i(elig), .found_o(a_found), .idx_o(a_pick)
  );

  ping_dual_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(cnt_clr), .inc_i(cnt_inc),
    .cnt_o(cnt), .mismatch_o(cnt_bad)
  );

  assign cnt_nx  = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign tmo_hit = cnt_nx >= {1'b0, tmo_q};

  always_comb begin
    st_n    = st;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    go_w    = 1'b0;
    go_a    = 1'b0;
    go_e    = 1'b0;
    afail_n = 1'b0;
    efail_n = 1'b0;
    if (local_esc_i || cnt_bad) begin
      st_n = PS_FAULT;
    end else begin
      case (st)
        PS_IDLE: if (en_q) begin
          st_n = PS_WAIT; go_w = 1'b1; cnt_clr = 1'b1;
        end
        PS_WAIT: if (cnt == CNT_W'(wait_len)) begin
          cnt_clr = 1'b1;
          if (a_found) begin st_n = PS_APING; go_a = 1'b1; end
          else         begin st_n = PS_EPING; go_e = 1'b1; end
        end else cnt_inc = 1'b1;
        PS_APING: if (alert_ack_i[a_tgt] || tmo_hit) begin
          afail_n = !alert_ack_i[a_tgt];
          st_n = PS_EPING; go_e = 1'b1; cnt_clr = 1'b1;
        end else cnt_inc = 1'b1;
        PS_EPING: if (esc_ack_i[e_tgt] || tmo_hit) begin
          efail_n = !esc_ack_i[e_tgt];
          st_n = PS_WAIT; go_w = 1'b1; cnt_clr = 1'b1;
        end else cnt_inc = 1'b1;
        PS_FAULT: st_n = PS_FAULT;
        default:  st_n = PS_FAULT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= PS_IDLE;
      en_q         <= 1'b0;
      tmo_q        <= CNT_W'(TMO_RST);
      wait_len     <= '0;
      a_tgt        <= '0;
      e_tgt        <= '0;
      alert_ping_o <= '0;
      esc_ping_o   <= '0;
      alert_fail_o <= 1'b0;
      esc_fail_o   <= 1'b0;
    end else begin
      st           <= st_n;
      en_q         <= en_q | (en_wr_i & en_i);
      if (tmo_wr_i) tmo_q <= tmo_i;
      alert_fail_o <= afail_n;
      esc_fail_o   <= efail_n;
      if (go_w) wait_len <= rnd[WAIT_W-1:0];
      if (go_a) begin
        a_tgt        <= a_pick;
        alert_ping_o <= {{(N_ALERT-1){1'b0}}, 1'b1} << a_pick;
      end else if (st_n != PS_APING) begin
        alert_ping_o <= '0;
      end
      if (go_e) begin
        e_tgt      <= e_pick;
        esc_ping_o <= {{(N_ESC-1){1'b0}}, 1'b1} << e_pick;
      end else if (st_n != PS_EPING) begin
        esc_ping_o <= '0;
      end
    end
  end

  p_one_ping_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({alert_ping_o, esc_ping_o}));
  p_en_sticky_r2: assert property (@(posedge clk) disable iff (rst) en_q |=> en_q);
  p_alert_elig_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(|alert_ping_o) |-> |(alert_ping_o & $past(elig)));
  p_ack_ends_r7: assert property (@(posedge clk) disable iff (rst)
    (st == PS_APING && alert_ack_i[a_tgt] && !local_esc_i) |=> (alert_ping_o == '0) && !alert_fail_o);
  p_afail_src_r8: assert property (@(posedge clk) disable iff (rst)
    alert_fail_o |-> $past(|alert_ping_o) && (alert_ping_o == '0));
  p_efail_src_r8: assert property (@(posedge clk) disable iff (rst)
    esc_fail_o |-> $past(|esc_ping_o) && (esc_ping_o == '0));
  p_local_esc_r10: assert property (@(posedge clk) disable iff (rst)
    local_esc_i |=> (st == PS_FAULT));
  p_fault_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (st == PS_FAULT) |=> (st == PS_FAULT) && (alert_ping_o == '0) && (esc_ping_o == '0)
                         && !alert_fail_o && !esc_fail_o);
  p_cnt_fault_r10: assert property (@(posedge clk) disable iff (rst)
    cnt_bad |=> (st == PS_FAULT));
endmodule

// File: tb/tb_ping_sched.sv
`timescale 1ns/1ps
module tb_ping_sched;
  localparam int NA = 8;
  localparam int NE = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en_wr = 1'b0, en_v = 1'b0, tmo_wr = 1'b0, lesc = 1'b0;
  logic [15:0]   tmo_v = '0;
  logic [NA-1:0] a_en = '0, a_open = '1, a_ack = '0;
  logic [NE-1:0] e_ack = '0;
  logic [NA-1:0] a_ping;
  logic [NE-1:0] e_ping;
  logic          a_fail, e_fail;

  always #4 clk = ~clk;

  ping_sched dut (
    .clk(clk), .rst(rst), .en_wr_i(en_wr), .en_i(en_v), .tmo_wr_i(tmo_wr), .tmo_i(tmo_v),
    .alert_en_i(a_en), .alert_open_i(a_open), .alert_ack_i(a_ack), .esc_ack_i(e_ack),
    .local_esc_i(lesc), .alert_ping_o(a_ping), .esc_ping_o(e_ping),
    .alert_fail_o(a_fail), .esc_fail_o(e_fail)
  );

  int n_chk = 0, n_bad = 0;
  int mode = 0, tmo_b = 256;
  bit lesc_skip = 1'b0;
  string tmo_tag = "R8";
  bit done = 1'b0;

  bit act = 1'b0, kind_a = 1'b0, had_end = 1'b0, last_end_a = 1'b0;
  logic [NA-1:0] avec;
  logic [NE-1:0] evec;
  int len = 0, ack_k = 0, tgt = 0, cyc = 0, last_end_cyc = 0;
  int a_starts = 0, e_starts = 0;

  task automatic chk(bit ok, string req, int actual, int expected);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, actual, expected, cyc);
    end
  endtask

  function automatic logic [NA-1:0] elig_f(logic [NA-1:0] en, logic [NA-1:0] open);
    return en & ~open;
  endfunction

  function automatic int exp_len(int k, int t);
    if (k > 0) return k;
    return (t == 0) ? 1 : t;
  endfunction

  function automatic int idx_of(logic [NA-1:0] v);
    for (int i = 0; i < NA; i++) if (v[i]) return i;
    return 0;
  endfunction

  // Monitor and responder
  always @(negedge clk) begin
    bit ended_a, ended_e, still;
    int t_eff;
    cyc++;
    ended_a = 1'b0;
    ended_e = 1'b0;
    if (rst) begin
      act = 1'b0; had_end = 1'b0; a_starts = 0; e_starts = 0;
      a_ack = '0; e_ack = '0;
    end else begin
      if (act) begin
        still = kind_a ? (a_ping == avec) : (e_ping == evec);
        if (still) begin
          len++;
          if (mode == 1 && len == ack_k) begin
            if (kind_a) a_ack[tgt] = 1'b1; else e_ack[tgt] = 1'b1;
          end
        end else begin
          if (!lesc_skip) begin
            chk(len == exp_len(ack_k, tmo_b), (ack_k > 0) ? "R7" : tmo_tag, len, exp_len(ack_k, tmo_b));
            chk((kind_a ? a_fail : e_fail) == (ack_k == 0), (ack_k > 0) ? "R7 R9" : "R8 R9",
                int'(kind_a ? a_fail : e_fail), int'(ack_k == 0));
          end
          ended_a = kind_a; ended_e = !kind_a;
          act = 1'b0; a_ack = '0; e_ack = '0;
          had_end = 1'b1; last_end_a = kind_a; last_end_cyc = cyc;
        end
      end
      if (a_fail && !ended_a) chk(1'b0, "R8 alert fail outside ping end", 1, 0);
      if (e_fail && !ended_e) chk(1'b0, "R8 esc fail outside ping end", 1, 0);
      if (!act && ((|a_ping) || (|e_ping))) begin
        chk($countones({a_ping, e_ping}) == 1, "R4", $countones({a_ping, e_ping}), 1);
        kind_a = |a_ping; avec = a_ping; evec = e_ping; len = 1; act = 1'b1;
        if (kind_a) begin
          a_starts++;
          tgt = idx_of(a_ping);
          chk((a_ping & elig_f(a_en, a_open)) != '0, "R3 R6", int'(a_ping), int'(elig_f(a_en, a_open)));
          chk(!had_end || (!last_end_a && last_end_cyc < cyc), "R5 gap before alert ping",
              cyc - last_end_cyc, 1);
        end else begin
          e_starts++;
          tgt = idx_of({{(NA-NE){1'b0}}, e_ping});
          if (elig_f(a_en, a_open) != '0)
            chk(had_end && last_end_a && last_end_cyc == cyc, "R5 esc follows alert",
                int'(had_end && last_end_a), 1);
          else
            chk(!had_end || (!last_end_a && last_end_cyc < cyc), "R6 alert slot skipped",
                int'(last_end_a), 0);
        end
        t_eff = (tmo_b == 0) ? 1 : tmo_b;
        ack_k = 0;
        if (mode == 1 && ($urandom % 3) != 0) ack_k = 1 + int'($urandom % t_eff);
        if (mode == 1 && ack_k == 1) begin
          if (kind_a) a_ack[tgt] = 1'b1; else e_ack[tgt] = 1'b1;
        end
        if (mode == 2) begin
          if (kind_a) begin a_ack = ~avec; e_ack = '1; end
          else        begin a_ack = '1; e_ack = ~evec; end
        end
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic do_reset();
    rst = 1'b1; en_wr = 1'b0; en_v = 1'b0; tmo_wr = 1'b0; lesc = 1'b0; lesc_skip = 1'b0;
    tmo_b = 256; tmo_tag = "R8";
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_tmo(int t);
    @(negedge clk); tmo_v = 16'(t); tmo_wr = 1'b1;
    @(negedge clk); tmo_wr = 1'b0; tmo_b = t;
  endtask

  task automatic write_en(bit v);
    @(negedge clk); en_v = v; en_wr = 1'b1;
    @(negedge clk); en_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    int s;
    void'($urandom(32'd20240611));
    // R1: reset state
    a_en = '0; a_open = '1; mode = 0;
    do_reset();
    chk(a_ping == '0 && e_ping == '0, "R1 pings after reset", int'({a_ping, e_ping}), 0);
    chk(!a_fail && !e_fail, "R1 fails after reset", int'({a_fail, e_fail}), 0);
    // R2: no pings before enable
    repeat (40) @(negedge clk);
    chk(a_starts + e_starts == 0, "R2 no ping before enable", a_starts + e_starts, 0);
    // R1: default limit 256, unanswered esc ping
    tmo_tag = "R1";
    write_en(1'b1);
    repeat (320) @(negedge clk);
    chk(e_starts >= 1, "R1 esc ping seen with default limit", e_starts, 1);

    // R3 R5 R7 R8 R11: random phases
    for (int ph = 0; ph < 4; ph++) begin
      mode = 1;
      a_en = NA'($urandom); a_open = NA'($urandom);
      s = int'($urandom % NA);
      a_en[s] = 1'b1; a_open[s] = 1'b0;
      do_reset();
      set_tmo(4 + int'($urandom % 20));
      write_en(1'b1);
      if (ph == 0) begin
        repeat (300) @(negedge clk);
        write_en(1'b0);
        s = e_starts;
        repeat (300) @(negedge clk);
        chk(e_starts > s, "R2 clear of enable ignored", e_starts, s + 1);
      end else begin
        repeat (1500) @(negedge clk);
      end
      chk(a_starts > 0 && e_starts > 0, "R5 rounds issued", a_starts, 1);
    end

    // R6: nothing eligible (enabled ones still open, locked ones disabled)
    mode = 1;
    a_en = 8'b1010_0110; a_open = 8'b1010_0110;
    do_reset(); set_tmo(6); write_en(1'b1);
    repeat (400) @(negedge clk);
    chk(a_starts == 0, "R6 no alert ping", a_starts, 0);
    chk(e_starts > 0, "R6 esc pings continue", e_starts, 1);

    // R11: limit 0 acts as 1, single eligible alert
    mode = 0;
    a_en = 8'b0001_0000; a_open = 8'b0000_0000;
    do_reset(); set_tmo(0); tmo_tag = "R11"; write_en(1'b1);
    repeat (200) @(negedge clk);
    chk(a_starts > 0, "R11 pings with zero limit", a_starts, 1);

    // R9: wrong-target and late acknowledges
    mode = 2;
    a_en = 8'b1111_0000; a_open = 8'b0011_0000;
    do_reset(); set_tmo(10); tmo_tag = "R9"; write_en(1'b1);
    repeat (400) @(negedge clk);
    chk(a_starts > 0 && e_starts > 0, "R9 pings under ack noise", e_starts, 1);

    // R10: local escalation during a ping
    mode = 0;
    a_en = 8'hFF; a_open = 8'h00;
    do_reset(); set_tmo(30); write_en(1'b1);
    while (!((|a_ping) || (|e_ping))) @(negedge clk);
    lesc_skip = 1'b1;
    lesc = 1'b1;
    @(negedge clk);
    lesc = 1'b0;
    chk(a_ping == '0 && e_ping == '0, "R10 pings drop", int'({a_ping, e_ping}), 0);
    s = a_starts + e_starts;
    repeat (300) @(negedge clk);
    chk(a_starts + e_starts == s, "R10 stays silent", a_starts + e_starts, s);
    chk(!a_fail && !e_fail, "R10 no fail pulses", int'({a_fail, e_fail}), 0);

    done = 1'b1;
    summary();
  end
endmodule